// File: doc/BRIEF.md
# Line Energy Detect Status Monitor

This block keeps one status bit that says whether signal energy is present on a network line. The analog front end raises a strobe on any cycle in which it sees valid energy, and a prescaler supplies a one-cycle tick once per millisecond. Any strobe sets the status bit at once. The bit clears only after a full window of millisecond ticks passes with no strobe. The window is a parameter of 256 ticks by default.

A hardware reset forces the bit to 1. The software reset input leaves the bit and the absence counter exactly as they were. The block also raises a one-cycle change pulse each time the status bit moves in either direction, so an interrupt controller can use it as an event source. Register access, the detector itself and interrupt merging sit outside the block.

Top module: `line_energy_monitor`

## Requirements
- R1: While `rst_n` is sampled low at a rising clock edge, the block forces `energy_on` to 1 and `energy_chg` to 0 after that edge, and clears the absence count.
- R2: A cycle with `energy_seen` high makes `energy_on` 1 after the next rising edge and restarts the absence count from zero.
- R3: `energy_on` falls to 0 after the edge that samples the TIMEOUT_MS-th `ms_tick` counted since the last strobe or hardware reset. After TIMEOUT_MS-1 such ticks it is still 1.
- R4: Cycles with `ms_tick` low and `energy_seen` low change neither `energy_on` nor the absence count.
- R5: The absence count saturates at TIMEOUT_MS. Further ticks keep `energy_on` at 0 and produce no change pulse. After the next strobe, a full TIMEOUT_MS window is again needed to clear the bit.
- R6: `energy_chg` is 1 for exactly the one cycle in which `energy_on` first shows a new value, and 0 in every other cycle.
- R7: `sw_rst` has no effect: `energy_on`, `energy_chg` and the absence count evolve as if it were low.
- R8: When `energy_seen` and `ms_tick` are high in the same cycle, the strobe wins. The bit is 1 and the count restarts from zero, so that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, synchronous, active low |
| sw_rst | input | 1 | Software reset request, active high, no effect on this block |
| energy_seen | input | 1 | Valid energy detected on the line this cycle |
| ms_tick | input | 1 | One-cycle millisecond tick from the prescaler |
| energy_on | output | 1 | Energy-present status, 1 = present |
| energy_chg | output | 1 | One-cycle pulse on every change of `energy_on` |

## Verification
The bench goes after the window edge. It checks that the bit holds through tick TIMEOUT_MS-1 and drops on tick TIMEOUT_MS. An off-by-one counter would drop one tick early or late. It checks a strobe coinciding with a tick, where a design that counted that tick would drop one tick early. It also checks that idle cycles without ticks are not counted. It drives software reset in the middle of a window: a design that cleared its count there would drop late, and one that cleared the bit would pulse falsely. It checks saturation, where a wrapping counter would raise the bit or pulse again. It applies a hardware reset while the bit is low, where a design that pulsed on that forced rise or kept the bit low would be caught.

// File: rtl/energy_mon_pkg.sv
// Package: shared constants and helpers for the line energy monitor.
// Assumes: timeouts are at least one tick.
package energy_mon_pkg;
    localparam int DEFAULT_TIMEOUT_MS = 256;

    // Width of a counter that must hold values 0..limit inclusive.
    function automatic int count_width(input int limit);
        return (limit < 1) ? 1 : $clog2(limit + 1);
    endfunction
endpackage

// File: rtl/lem_absence_timer.sv
// Module: counts millisecond ticks that pass with no energy strobe.
// Raises expire combinationally in the cycle whose tick completes the window.
// Assumes: TIMEOUT_MS >= 1; ms_tick is a single-cycle pulse.
module lem_absence_timer #(
    parameter int TIMEOUT_MS = energy_mon_pkg::DEFAULT_TIMEOUT_MS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic energy_seen,
    input  logic ms_tick,
    output logic expire
);
    localparam int CW = energy_mon_pkg::count_width(TIMEOUT_MS);
    localparam logic [CW-1:0] LIMIT     = CW'(TIMEOUT_MS);
    localparam logic [CW-1:0] LAST_STEP = CW'(TIMEOUT_MS - 1);

    logic [CW-1:0] absent_cnt;

    // Purpose: restart on energy, advance on ticks, hold at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            absent_cnt <= '0;
        end else if (energy_seen) begin
            absent_cnt <= '0;
        end else if (ms_tick && (absent_cnt != LIMIT)) begin
            absent_cnt <= absent_cnt + 1'b1;
        end
    end

    // Purpose: flag the tick that completes the absence window.
    always_comb begin
        expire = !energy_seen && ms_tick && (absent_cnt == LAST_STEP);
    end

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        absent_cnt <= LIMIT);

    // R5
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (absent_cnt == LIMIT && !energy_seen) |=> absent_cnt == LIMIT);

    // R4
    idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!energy_seen && !ms_tick) |=> $stable(absent_cnt));

    // R8
    strobe_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        energy_seen |=> absent_cnt == '0);
endmodule

// File: rtl/lem_status_flag.sv
// Module: holds the energy-on bit and produces its change pulse.
// The pulse is registered together with the bit, so both appear in the same cycle.
// Assumes: set and expire come from the same cycle's inputs; set wins.
module lem_status_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_on,
    input  logic expire,
    output logic energy_on,
    output logic energy_chg
);
    logic next_on;

    // Purpose: choose the next bit value, with set priority over clear.
    always_comb begin
        if (set_on) begin
            next_on = 1'b1;
        end else if (expire) begin
            next_on = 1'b0;
        end else begin
            next_on = energy_on;
        end
    end

    // Purpose: store the bit; the reset value is "energy present".
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            energy_on  <= 1'b1;
            energy_chg <= 1'b0;
        end else begin
            energy_on  <= next_on;
            energy_chg <= (next_on != energy_on);
        end
    end

    // R2
    set_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_on |=> energy_on);

    // R6
    chg_on_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (energy_on != $past(energy_on))) |-> energy_chg);

    // R6
    chg_only_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        energy_chg |-> (energy_on != $past(energy_on)));
endmodule

// File: rtl/line_energy_monitor.sv
// Module: top of the line energy monitor.
// Joins the absence timer and the status flag. The software reset input is
// accepted but, by design, changes neither the bit nor the timer.
// Assumes: rst_n is synchronous to clk; ms_tick is one cycle wide.
module line_energy_monitor #(
    parameter int TIMEOUT_MS = energy_mon_pkg::DEFAULT_TIMEOUT_MS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_rst,
    input  logic energy_seen,
    input  logic ms_tick,
    output logic energy_on,
    output logic energy_chg
);
    logic window_done;

    lem_absence_timer #(.TIMEOUT_MS(TIMEOUT_MS)) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .energy_seen(energy_seen),
        .ms_tick    (ms_tick),
        .expire     (window_done)
    );

    lem_status_flag i_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_on    (energy_seen),
        .expire    (window_done),
        .energy_on (energy_on),
        .energy_chg(energy_chg)
    );

    // R3
    drop_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(energy_on) |-> ($past(ms_tick) && !$past(energy_seen)));

    // R7 (and R4): an idle cycle holds the bit whether or not sw_rst is high
    sw_rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_rst && !energy_seen && !ms_tick) |=> ($stable(energy_on) && !energy_chg));
endmodule

// File: tb/test_line_energy_monitor.sv
// Bench: directed corners plus seeded random stimulus against a bench model.
module test_line_energy_monitor;
    localparam int TO = 8;

    logic clk = 1'b0;
    logic rst_n, sw_rst, energy_seen, ms_tick;
    logic energy_on, energy_chg;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // bench model state
    int  m_cnt;
    bit  m_on;
    bit  m_chg;

    always #4 clk = ~clk;

    line_energy_monitor #(.TIMEOUT_MS(TO)) i_line_energy_monitor (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .energy_seen(energy_seen),
        .ms_tick(ms_tick), .energy_on(energy_on), .energy_chg(energy_chg)
    );

    // expected next state from the requirements (sw_rst deliberately unused, R7)
    function automatic void model_next(input bit r, input bit e, input bit t,
                                       input int cnt, input bit on,
                                       output int n_cnt, output bit n_on, output bit n_chg);
        if (!r) begin
            n_cnt = 0; n_on = 1'b1; n_chg = 1'b0;
        end else begin
            n_on = on;
            n_cnt = cnt;
            if (e) begin
                n_cnt = 0; n_on = 1'b1;
            end else if (t && cnt < TO) begin
                n_cnt = cnt + 1;
                if (n_cnt == TO) n_on = 1'b0;
            end
            n_chg = (n_on != on);
        end
    endfunction

    task automatic check(input logic act, input bit exp, input string what, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s act=%0b exp=%0b", tag, what, act, exp);
        end
    endtask

    // one clock: drive at negedge, update model, compare at next negedge
    task automatic step(input bit r, input bit e, input bit t, input bit s, input string tag);
        int nc; bit no, nch;
        rst_n = r; energy_seen = e; ms_tick = t; sw_rst = s;
        model_next(r, e, t, m_cnt, m_on, nc, no, nch);
        @(posedge clk);
        m_cnt = nc; m_on = no; m_chg = nch;
        @(negedge clk);
        check(energy_on, m_on, "energy_on", tag);
        check(energy_chg, m_chg, "energy_chg", tag);
    endtask

    initial begin
        rst_n = 1'b0; sw_rst = 1'b0; energy_seen = 1'b0; ms_tick = 1'b0;
        m_cnt = 0; m_on = 1'b1; m_chg = 1'b0;
        void'($urandom(32'd4242));
        @(negedge clk);
        // R1: reset state
        for (int i = 0; i < 3; i++) step(0, 0, 1, 0, "R1");
        // R3/R4: ticks with idle gaps, bit holds through tick TO-1
        for (int i = 0; i < TO - 1; i++) begin
            step(1, 0, 1, 0, "R3");
            step(1, 0, 0, 0, "R4");
        end
        step(1, 0, 1, 0, "R3");          // TO-th tick: drop, pulse
        check(energy_chg, 1'b1, "energy_chg at drop", "R6");
        step(1, 0, 0, 0, "R6");          // pulse gone
        // R5: saturation
        for (int i = 0; i < 3 * TO; i++) step(1, 0, 1, 0, "R5");
        // R7: software reset while low
        for (int i = 0; i < 4; i++) step(1, 0, i[0], 1, "R7");
        // R2: strobe raises the bit
        step(1, 1, 0, 0, "R2");
        check(energy_on, 1'b1, "energy_on after strobe", "R2");
        // R8: strobe together with tick restarts window
        for (int i = 0; i < 5; i++) step(1, 0, 1, 0, "R8");
        step(1, 1, 1, 0, "R8");
        for (int i = 0; i < TO - 1; i++) step(1, 0, 1, 0, "R8");
        check(energy_on, 1'b1, "energy_on before window end", "R8");
        step(1, 0, 1, 0, "R8");
        check(energy_on, 1'b0, "energy_on at window end", "R8");
        // R7: software reset mid-window keeps the count
        step(1, 1, 0, 0, "R2");
        for (int i = 0; i < 4; i++) step(1, 0, 1, 0, "R7");
        for (int i = 0; i < 3; i++) step(1, 0, 1, 1, "R7");
        for (int i = 0; i < TO - 7; i++) step(1, 0, 1, 0, "R7");
        check(energy_on, 1'b0, "energy_on after sw_rst window", "R7");
        // R1: hardware reset while low
        step(0, 0, 0, 0, "R1");
        check(energy_on, 1'b1, "energy_on after hw reset", "R1");
        check(energy_chg, 1'b0, "energy_chg after hw reset", "R1");
        // random phase
        for (int i = 0; i < 4000; i++) begin
            bit r, e, t, s;
            r = ($urandom % 300) != 0;
            e = ($urandom % 24) == 0;
            t = ($urandom % 2) == 0;
            s = ($urandom % 8) == 0;
            step(r, e, t, s, !r ? "R1" : (e && t) ? "R8" : e ? "R2" : s ? "R7" :
                             t ? "R3" : "R4");
        end
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule